// File: doc/BRIEF.md
# Supply Supervisor Reset Timing Controller

This block is the digital timing core of a supply-voltage supervisor. Two comparator flags come in from the analog side. One says the supply sits above the upper (release) threshold. The other says it has dropped below the lower (detection) threshold. A manual-reset request also comes in. All three are asynchronous, so each passes through a two-flop synchronizer. From them the block drives an active-low system reset. Reset is released only after a long counted delay once the supply is good. It is reasserted after a short counted delay when the supply drops or a qualified manual reset arrives.

The two thresholds form a hysteresis band. Once the supply has been seen below detection, it must climb past release before counting starts. Once reset is released, movement inside the band leaves it released. A manual-reset request counts only after it has been held for a minimum number of cycles. While a qualified request is held, reset stays asserted. When it is let go, the full release delay runs again from zero. A one-cycle pulse marks every release.

Top module: `rst_supervisor_ctrl`

## Requirements
- R1: After synchronous reset, `rst_n_o` is 0 and `released_o` is 0. Both stay 0 while no supply-good flag has been seen.
- R2: From the held state, when `above_rel_i` rises (with `below_det_i` low and `man_rst_i` low), `rst_n_o` rises exactly 4+REL_CYC clock edges later and not before.
- R3: While neither comparator flag is high, the output keeps its level. It stays 0 if reset is held and stays 1 if reset was released.
- R4: From the released state, when `below_det_i` rises, `rst_n_o` falls exactly 3+AST_CYC clock edges later.
- R5: A `man_rst_i` high for MRW_CYC cycles or more in the released state makes `rst_n_o` fall 3+MRW_CYC+AST_CYC edges after it rose.
- R6: A `man_rst_i` pulse shorter than MRW_CYC cycles has no effect. The output stays released, and a running release count is not disturbed.
- R7: When a qualified `man_rst_i` falls with the supply good, `rst_n_o` rises exactly 3+REL_CYC edges after the fall.
- R8: A detection flag during the release count aborts it. The next release needs a new `above_rel_i` and a full REL_CYC count.
- R9: A qualified manual reset during the release count aborts it. The count restarts in full when `man_rst_i` falls.
- R10: `released_o` is high for exactly one cycle, in the first cycle that `rst_n_o` is 1 after being 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| above_rel_i | input | 1 | Comparator: supply above release threshold (asynchronous) |
| below_det_i | input | 1 | Comparator: supply below detection threshold (asynchronous) |
| man_rst_i | input | 1 | Manual reset request, active high (asynchronous) |
| rst_n_o | output | 1 | Active-low system reset |
| released_o | output | 1 | One-cycle pulse when reset is released |

## Verification
The bench builds the controller with REL_CYC=40, AST_CYC=4 and MRW_CYC=8, in place of defaults that stand for tens of milliseconds. The short release count lets every release edge be checked to the exact cycle. It also makes it practical to land aborts and short manual pulses in the middle of a count. An MRW_CYC of 8 lets the bench test both sides of the qualification limit (7 and 8 cycles) directly.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [1:0] {
        ST_HELD   = 2'd0,
        ST_RELCNT = 2'd1,
        ST_RUN    = 2'd2,
        ST_ASSERT = 2'd3
    } rsc_state_e;

    typedef struct packed {
        logic above_rel;
        logic below_det;
        logic man_req;
    } rsc_flags_t;

    localparam int FLAG_W = $bits(rsc_flags_t);

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/rsc_mr_qual.sv
module rsc_mr_qual #(
    parameter int MIN_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic valid_o
);
    localparam int QW = $clog2(MIN_CYC + 1);
    localparam logic [QW-1:0] Q_LAST = QW'(MIN_CYC - 1);

    logic [QW-1:0] run_q;
    logic          valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            valid_q <= 1'b0;
        end else if (!req_i) begin
            run_q   <= '0;
            valid_q <= 1'b0;
        end else if (run_q == Q_LAST) begin
            valid_q <= 1'b1;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign valid_o = valid_q;

    // R6
    valid_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> $past(req_i));
endmodule

// File: rtl/rsc_timer.sv
module rsc_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] SAT = '1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != SAT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/rst_supervisor_ctrl.sv
module rst_supervisor_ctrl
    import rsc_pkg::*;
#(
    parameter int REL_CYC = 50000,
    parameter int AST_CYC = 18,
    parameter int MRW_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic above_rel_i,
    input  logic below_det_i,
    input  logic man_rst_i,
    output logic rst_n_o,
    output logic released_o
);
    localparam int CW = $clog2(max_int(REL_CYC, AST_CYC) + 1);
    localparam logic [CW-1:0] REL_LAST = CW'(REL_CYC - 1);
    localparam logic [CW-1:0] AST_LAST = CW'(AST_CYC - 1);

    rsc_flags_t raw_flags, syn_flags;
    rsc_state_e state_q, state_d;
    logic       sup_good_q;
    logic       mr_valid;
    logic       rel_pulse_q;
    logic [CW-1:0] cnt;

    assign raw_flags = '{above_rel: above_rel_i, below_det: below_det_i, man_req: man_rst_i};

    rsc_sync #(.WIDTH(FLAG_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_flags),
        .q_o (syn_flags)
    );

    rsc_mr_qual #(.MIN_CYC(MRW_CYC)) u_mrq (
        .clk     (clk),
        .rst     (rst),
        .req_i   (syn_flags.man_req),
        .valid_o (mr_valid)
    );

    rsc_timer #(.CW(CW)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .clr_i (state_d != state_q),
        .cnt_o (cnt)
    );

    // Hysteresis latch: set above release, cleared below detection.
    always_ff @(posedge clk) begin
        if (rst) begin
            sup_good_q <= 1'b0;
        end else if (syn_flags.below_det) begin
            sup_good_q <= 1'b0;
        end else if (syn_flags.above_rel) begin
            sup_good_q <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HELD: begin
                if (sup_good_q && !syn_flags.below_det && !syn_flags.man_req)
                    state_d = ST_RELCNT;
            end
            ST_RELCNT: begin
                if (syn_flags.below_det || mr_valid)
                    state_d = ST_HELD;
                else if (cnt == REL_LAST)
                    state_d = ST_RUN;
            end
            ST_RUN: begin
                if (syn_flags.below_det || mr_valid)
                    state_d = ST_ASSERT;
            end
            ST_ASSERT: begin
                if (cnt == AST_LAST)
                    state_d = ST_HELD;
            end
            default: state_d = ST_HELD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_HELD;
            rel_pulse_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            rel_pulse_q <= (state_q == ST_RELCNT) && (state_d == ST_RUN);
        end
    end

    assign rst_n_o    = (state_q == ST_RUN) || (state_q == ST_ASSERT);
    assign released_o = rel_pulse_q;

    // R1
    reset_holds_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rst_n_o && !released_o));

    // R3
    band_keeps_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HELD && !sup_good_q) |=> !rst_n_o);

    // R4
    detect_starts_assert_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && syn_flags.below_det) |=> (state_q == ST_ASSERT));

    // R8
    detect_aborts_count_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RELCNT && syn_flags.below_det) |=> (state_q == ST_HELD && !sup_good_q));

    // R9
    mr_aborts_count_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RELCNT && mr_valid) |=> (state_q == ST_HELD));

    // R2
    count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RELCNT) |-> (cnt <= REL_LAST));

    // R10
    pulse_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        released_o |-> (rst_n_o && !$past(rst_n_o)));
endmodule

// File: tb/rst_supervisor_ctrl_tb.sv
module rst_supervisor_ctrl_tb;
    localparam int REL = 40;
    localparam int AST = 4;
    localparam int MRW = 8;

    // vector fields: [19] above, [18] below, [17] manual, [16:1] wait edges, [0] expected rst_n
    localparam int NV = 9;
    localparam logic [19:0] VECS [NV] = '{
        {1'b0, 1'b1, 1'b0, 16'(10),      1'b0},
        {1'b0, 1'b0, 1'b0, 16'(10),      1'b0},
        {1'b1, 1'b0, 1'b0, 16'(REL + 10), 1'b1},
        {1'b0, 1'b0, 1'b0, 16'(20),      1'b1},
        {1'b1, 1'b0, 1'b0, 16'(5),       1'b1},
        {1'b0, 1'b0, 1'b0, 16'(5),       1'b1},
        {1'b0, 1'b1, 1'b0, 16'(AST + 10), 1'b0},
        {1'b0, 1'b0, 1'b0, 16'(REL + 10), 1'b0},
        {1'b1, 1'b0, 1'b0, 16'(REL + 10), 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic above = 1'b0;
    logic below = 1'b0;
    logic mr = 1'b0;
    logic rst_n;
    logic rel_p;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rst_supervisor_ctrl #(.REL_CYC(REL), .AST_CYC(AST), .MRW_CYC(MRW)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .above_rel_i (above),
        .below_det_i (below),
        .man_rst_i   (mr),
        .rst_n_o     (rst_n),
        .released_o  (rel_p)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        @(negedge clk);
        edges(3);
        chk(rst_n, 1'b0, "R1 rst_n during reset");
        chk(rel_p, 1'b0, "R1 pulse during reset");
        rst = 1'b0;
        edges(6);
        chk(rst_n, 1'b0, "R1 rst_n after reset, no supply flag");

        // vector walk: hysteresis band and basic release/detect levels
        for (int i = 0; i < NV; i++) begin
            above = VECS[i][19];
            below = VECS[i][18];
            mr    = VECS[i][17];
            edges(int'(VECS[i][16:1]));
            chk(rst_n, VECS[i][0], $sformatf("R3 vector %0d level", i));
        end

        // R4: detection timing from released state
        above = 1'b0; below = 1'b1;
        edges(2 + AST);
        chk(rst_n, 1'b1, "R4 still released before assert delay");
        edges(1);
        chk(rst_n, 1'b0, "R4 asserted after assert delay");

        // R2 / R10: exact release timing and pulse
        below = 1'b0; above = 1'b1;
        edges(3 + REL);
        chk(rst_n, 1'b0, "R2 held one edge before release");
        chk(rel_p, 1'b0, "R10 no pulse before release");
        edges(1);
        chk(rst_n, 1'b1, "R2 released at 4+REL");
        chk(rel_p, 1'b1, "R10 pulse on release cycle");
        edges(1);
        chk(rel_p, 1'b0, "R10 pulse lasts one cycle");

        // R6: manual pulse one cycle short of qualifying
        mr = 1'b1;
        edges(MRW - 1);
        mr = 1'b0;
        edges(20);
        chk(rst_n, 1'b1, "R6 short manual pulse ignored");

        // R5: qualifying manual reset
        mr = 1'b1;
        edges(2 + MRW + AST);
        chk(rst_n, 1'b1, "R5 released before manual assert completes");
        edges(1);
        chk(rst_n, 1'b0, "R5 manual reset asserted");
        edges(10);
        // R7: release after manual reset falls
        mr = 1'b0;
        edges(2 + REL);
        chk(rst_n, 1'b0, "R7 held one edge before release");
        edges(1);
        chk(rst_n, 1'b1, "R7 released 3+REL after manual fall");

        // R6: short pulse inside a running count leaves timing intact
        mr = 1'b1;
        edges(MRW + AST + 6);
        mr = 1'b0;
        edges(10);
        mr = 1'b1;
        edges(MRW - 1);
        mr = 1'b0;
        edges(REL - 6 - MRW - 1);
        chk(rst_n, 1'b0, "R6 count undisturbed, held before release");
        edges(1);
        chk(rst_n, 1'b1, "R6 count undisturbed, release on time");

        // R9: qualified manual reset aborts a running count
        mr = 1'b1;
        edges(MRW + AST + 6);
        mr = 1'b0;
        edges(10);
        mr = 1'b1;
        edges(REL);
        chk(rst_n, 1'b0, "R9 count aborted by manual reset");
        mr = 1'b0;
        edges(2 + REL);
        chk(rst_n, 1'b0, "R9 full count restarts after fall");
        edges(1);
        chk(rst_n, 1'b1, "R9 released after restarted count");

        // R8: detection during release count aborts it
        above = 1'b0; below = 1'b1;
        edges(AST + 6);
        below = 1'b0; above = 1'b1;
        edges(10);
        above = 1'b0; below = 1'b1;
        edges(5);
        below = 1'b0;
        edges(REL);
        chk(rst_n, 1'b0, "R8 band after aborted count stays held");
        above = 1'b1;
        edges(3 + REL);
        chk(rst_n, 1'b0, "R8 held one edge before new release");
        edges(1);
        chk(rst_n, 1'b1, "R8 released after full new count");

        // R1: reset mid-run forces hold
        rst = 1'b1;
        edges(2);
        chk(rst_n, 1'b0, "R1 reset from released state");
        rst = 1'b0;
        edges(1);
        chk(rst_n, 1'b0, "R1 held right after reset");

        summary();
    end
endmodule